// File: doc/BRIEF.md
# Register-Programmed Pulse-Width Modulator

This block produces one pulse-width-modulated output. Software sets the period and the high time through a small register port that follows the AXI4-Lite handshake. The core holds a down-counter. The counter starts each period at period−1 and counts down to zero. The output is high while the counter value is below the programmed width. The high pulse therefore sits at the end of every period. A width larger than the period gives a constant low output, never a constant high one.

Period and width writes land in staging registers. They take effect only after a load request, and then only at the next period boundary, so a period that is running always finishes with its old settings. A counter-hold control freezes the counter at the top of the period and forces the output low. While the counter is held, a load request is applied at once. The port also carries fixed identification words and a free scratch word. The bus and the counter share one clock.

Top module: `pwmr_top`

## Requirements
- R1: Reads at byte offset 0x00 return the VERSION parameter and at 0x04 the CORE_ID parameter. Reads at 0x0C return the constant 0x504C5347. After reset, reads of 0x08, 0x10, 0x14 and 0x18 return zero.
- R2: The word at 0x08 is a 32-bit read/write scratch word. Writes to 0x00, 0x04 and 0x0C leave their read values unchanged.
- R3: Reads of unmapped offsets, or of addresses whose two low bits are not zero, return zero. Every write response and every read response carries code 0 (OKAY).
- R4: The period is P cycles (programmed at 0x14) and the width is W (programmed at 0x18), with 0 < W ≤ P. While running, the output is low for the first P−W cycles of each period and high for the last W cycles.
- R5: W = 0 gives a constant low output. W = P gives a constant high output.
- R6: Any W greater than P gives a constant low output.
- R7: Bit 0 of the configuration word at 0x10 is the counter hold, active high, and it reads back as written. While the hold is set, the output is low. When the hold is cleared, a full period starts with its low part.
- R8: Bit 1 of the configuration word is the load request. It clears itself after one cycle and always reads back as 0. Period and width writes without a load request do not change the output.
- R9: A load request made while running takes effect at the next period boundary, and the period that is running finishes with its old width. A load request made while the hold is set takes effect at once.
- R10: After reset the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the counter |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| aw_addr | input | ADDR_W | Write byte address |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | 32 | Write data |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_addr | input | ADDR_W | Read byte address |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data taken |
| r_data | output | 32 | Read data |
| r_resp | output | 2 | Read response code |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The waveform is compared cycle by cycle against an ideal down-count for several (P, W) pairs: a mid-range duty, zero width, width equal to the period, width above the period, and a one-cycle period. Each pair targets a different branch: pulse placement at the end of the period, the two saturating ends, and the clamp that turns an oversized width into a constant low. A separate run records the lengths of successive high pulses around a width change. The first pulse must keep the old length and the second must take the new one, which separates staged writes from immediate writes and boundary loads from mid-period loads. Register reads cover the constant words, the scratch word, the ignored writes and the misaligned addresses.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;
   localparam int unsigned DATA_W  = 32;
   localparam logic [31:0] IDENT   = 32'h504C_5347;
   localparam int unsigned IX_VER  = 0;
   localparam int unsigned IX_ID   = 1;
   localparam int unsigned IX_SCR  = 2;
   localparam int unsigned IX_IDNT = 3;
   localparam int unsigned IX_CFG  = 4;
   localparam int unsigned IX_PER  = 5;
   localparam int unsigned IX_WID  = 6;
   localparam int unsigned CFG_HOLD_BIT = 0;
   localparam int unsigned CFG_LOAD_BIT = 1;
   localparam logic [1:0]  RESP_OK = 2'b00;
endpackage

// File: rtl/pwmr_regs.sv
module pwmr_regs
   import pwmr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned CNT_W   = 16,
   parameter logic [31:0] VERSION = 32'h0001_0200,
   parameter logic [31:0] CORE_ID = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [1:0]        b_resp,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              cfg_hold,
   output logic              load_pls,
   output logic [CNT_W-1:0]  shd_period,
   output logic [CNT_W-1:0]  shd_width
);
   localparam int unsigned WIX_W = ADDR_W - 2;

   logic              wr_go, rd_go, wr_ok, rd_ok;
   logic [WIX_W-1:0]  wr_ix, rd_ix;
   logic [DATA_W-1:0] scratch_q, rd_word;

   assign wr_go    = aw_valid && w_valid && !b_valid;
   assign rd_go    = ar_valid && !r_valid;
   assign aw_ready = wr_go;
   assign w_ready  = wr_go;
   assign ar_ready = rd_go;
   assign b_resp   = RESP_OK;
   assign r_resp   = RESP_OK;
   assign wr_ix    = aw_addr[ADDR_W-1:2];
   assign rd_ix    = ar_addr[ADDR_W-1:2];
   assign wr_ok    = (aw_addr[1:0] == 2'b00);
   assign rd_ok    = (ar_addr[1:0] == 2'b00);

   always_comb begin
      rd_word = '0;
      if (rd_ok) begin
         case (rd_ix)
            WIX_W'(IX_VER):  rd_word = VERSION;
            WIX_W'(IX_ID):   rd_word = CORE_ID;
            WIX_W'(IX_SCR):  rd_word = scratch_q;
            WIX_W'(IX_IDNT): rd_word = IDENT;
            WIX_W'(IX_CFG):  rd_word[CFG_HOLD_BIT] = cfg_hold;
            WIX_W'(IX_PER):  rd_word = DATA_W'(shd_period);
            WIX_W'(IX_WID):  rd_word = DATA_W'(shd_width);
            default:         rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_valid    <= 1'b0;
         r_valid    <= 1'b0;
         r_data     <= '0;
         scratch_q  <= '0;
         cfg_hold   <= 1'b0;
         load_pls   <= 1'b0;
         shd_period <= '0;
         shd_width  <= '0;
      end else begin
         load_pls <= 1'b0;
         if (wr_go) b_valid <= 1'b1;
         else if (b_ready) b_valid <= 1'b0;
         if (rd_go) begin
            r_valid <= 1'b1;
            r_data  <= rd_word;
         end else if (r_ready) begin
            r_valid <= 1'b0;
         end
         if (wr_go && wr_ok) begin
            case (wr_ix)
               WIX_W'(IX_SCR): scratch_q <= w_data;
               WIX_W'(IX_CFG): begin
                  cfg_hold <= w_data[CFG_HOLD_BIT];
                  load_pls <= w_data[CFG_LOAD_BIT];
               end
               WIX_W'(IX_PER): shd_period <= w_data[CNT_W-1:0];
               WIX_W'(IX_WID): shd_width  <= w_data[CNT_W-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pwmr_core.sv
module pwmr_core #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_hold,
   input  logic             load_pls,
   input  logic [CNT_W-1:0] shd_period,
   input  logic [CNT_W-1:0] shd_width,
   output logic             pwm_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] period_o,
   output logic [CNT_W-1:0] width_o
);
   logic [CNT_W-1:0] cnt_q, per_q, wid_q, next_per;
   logic             pend_q, at_edge, apply_now, pwm_raw;

   function automatic logic [CNT_W-1:0] top_of(input logic [CNT_W-1:0] p);
      return (p == '0) ? '0 : p - 1'b1;
   endfunction

   assign at_edge   = cfg_hold || (cnt_q == '0);
   assign apply_now = (load_pls || pend_q) && at_edge;
   assign next_per  = apply_now ? shd_period : per_q;
   assign pwm_raw   = !cfg_hold && (wid_q <= per_q) && (cnt_q < wid_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= '0;
         wid_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= (pend_q || load_pls) && !apply_now;
         if (apply_now) begin
            per_q <= shd_period;
            wid_q <= shd_width;
         end
         if (at_edge) cnt_q <= top_of(next_per);
         else         cnt_q <= cnt_q - 1'b1;
      end
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic pwm_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= pwm_raw;
         end
         assign pwm_o = pwm_q;
      end else begin : g_comb_out
         assign pwm_o = pwm_raw;
      end
   endgenerate

   assign cnt_o    = cnt_q;
   assign period_o = per_q;
   assign width_o  = wid_q;
endmodule

// File: rtl/pwmr_top.sv
module pwmr_top
   import pwmr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned CNT_W   = 16,
   parameter bit          REG_OUT = 1'b0,
   parameter logic [31:0] VERSION = 32'h0001_0200,
   parameter logic [31:0] CORE_ID = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [31:0]       w_data,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [1:0]        b_resp,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [31:0]       r_data,
   output logic [1:0]        r_resp,
   output logic              pwm_out
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach byte offset 0x18");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
   endgenerate

   logic             cfg_hold, load_pls;
   logic [CNT_W-1:0] shd_period, shd_width, cnt_v, per_v, wid_v;

   pwmr_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .VERSION(VERSION), .CORE_ID(CORE_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
      .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
      .cfg_hold(cfg_hold), .load_pls(load_pls),
      .shd_period(shd_period), .shd_width(shd_width)
   );

   pwmr_core #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_core (
      .clk(clk), .rst_n(rst_n),
      .cfg_hold(cfg_hold), .load_pls(load_pls),
      .shd_period(shd_period), .shd_width(shd_width),
      .pwm_o(pwm_out), .cnt_o(cnt_v), .period_o(per_v), .width_o(wid_v)
   );
endmodule

// File: rtl/pwmr_chk.sv
module pwmr_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             b_valid,
   input logic [1:0]       b_resp,
   input logic             r_valid,
   input logic [1:0]       r_resp,
   input logic             cfg_hold,
   input logic             load_pls,
   input logic [CNT_W-1:0] cnt_v,
   input logic [CNT_W-1:0] per_v,
   input logic [CNT_W-1:0] wid_v,
   input logic             pwm
);
   assert_okay_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid || r_valid) |-> (b_resp == 2'b00 && r_resp == 2'b00));

   assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (per_v != '0) |-> (cnt_v < per_v));

   assert_wide_is_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((wid_v > per_v) && ($past(wid_v) > $past(per_v))) |-> !pwm);

   assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hold && $past(cfg_hold)) |-> !pwm);

   assert_load_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_pls |=> !load_pls);

   assert_keep_mid_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_v != '0 && !cfg_hold) |=> ($stable(per_v) && $stable(wid_v)));
endmodule

bind pwmr_top pwmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .b_valid(b_valid), .b_resp(b_resp), .r_valid(r_valid), .r_resp(r_resp),
   .cfg_hold(cfg_hold), .load_pls(load_pls),
   .cnt_v(cnt_v), .per_v(per_v), .wid_v(wid_v), .pwm(pwm_out)
);

// File: tb/pwmr_top_tb.sv
module pwmr_top_tb;
   localparam int ADDR_W = 8;
   localparam logic [31:0] VER = 32'h0001_0200;
   localparam logic [31:0] CID = 32'h0000_00A5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic aw_valid = 0, w_valid = 0, ar_valid = 0;
   logic b_ready = 1, r_ready = 1;
   logic [ADDR_W-1:0] aw_addr = '0, ar_addr = '0;
   logic [31:0] w_data = '0;
   logic aw_ready, w_ready, b_valid, ar_ready, r_valid, pwm_out;
   logic [1:0] b_resp, r_resp;
   logic [31:0] r_data;

   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pwmr_top #(.ADDR_W(ADDR_W), .CNT_W(16), .VERSION(VER), .CORE_ID(CID)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
      .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
      .pwm_out(pwm_out)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d,
                         output logic [1:0] resp);
      @(negedge clk);
      aw_valid = 1; w_valid = 1; aw_addr = a; w_data = d;
      @(posedge clk);
      @(negedge clk);
      aw_valid = 0; w_valid = 0;
      resp = b_valid ? b_resp : 2'b11;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d,
                         output logic [1:0] resp);
      @(negedge clk);
      ar_valid = 1; ar_addr = a;
      @(posedge clk);
      @(negedge clk);
      ar_valid = 0;
      d = r_valid ? r_data : 32'hDEAD_BEEF;
      resp = r_valid ? r_resp : 2'b11;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [1:0] rs;
      bus_wr(a, d, rs);
      chk(rs == 2'b00, "R3 write response", {30'b0, rs}, 0);
   endtask

   task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string req);
      logic [31:0] d;
      logic [1:0] rs;
      bus_rd(a, d, rs);
      chk(d == e && rs == 2'b00, req, d, e);
   endtask

   // hold counter, stage P/W, load while held, then release; sample 2P cycles
   task automatic run_pattern(input int p, input int w, input string req);
      int bad = 0;
      wr(8'h10, 32'h1);
      wr(8'h14, p);
      wr(8'h18, w);
      wr(8'h10, 32'h3);
      wr(8'h10, 32'h0);
      for (int i = 0; i < 2 * p; i++) begin
         bit e = (w <= p) && ((p - 1 - (i % p)) < w);
         if (i > 0) @(negedge clk);
         if (pwm_out !== e) bad++;
      end
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic test_reset_state;
      chk(pwm_out == 1'b0, "R10 output after reset", pwm_out, 0);
      rd_expect(8'h00, VER, "R1 version");
      rd_expect(8'h04, CID, "R1 core id");
      rd_expect(8'h0C, 32'h504C5347, "R1 ident");
      rd_expect(8'h08, 0, "R1 scratch reset");
      rd_expect(8'h10, 0, "R1 config reset");
      rd_expect(8'h14, 0, "R1 period reset");
      rd_expect(8'h18, 0, "R1 width reset");
   endtask

   task automatic test_regs;
      wr(8'h08, 32'hA5C3_0F96);
      rd_expect(8'h08, 32'hA5C3_0F96, "R2 scratch readback");
      wr(8'h08, 32'h5A3C_F069);
      rd_expect(8'h08, 32'h5A3C_F069, "R2 scratch second pattern");
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h04, 32'h1234_5678);
      wr(8'h0C, 32'h0);
      rd_expect(8'h00, VER, "R2 version write ignored");
      rd_expect(8'h04, CID, "R2 id write ignored");
      rd_expect(8'h0C, 32'h504C5347, "R2 ident write ignored");
      rd_expect(8'h1C, 0, "R3 unmapped 0x1C");
      rd_expect(8'h40, 0, "R3 unmapped 0x40");
      rd_expect(8'h09, 0, "R3 misaligned read");
   endtask

   task automatic test_patterns;
      run_pattern(10, 3, "R4 P=10 W=3");
      run_pattern(7, 1, "R4 P=7 W=1");
      run_pattern(6, 0, "R5 W=0 low");
      run_pattern(6, 6, "R5 W=P high");
      run_pattern(1, 1, "R5 P=1 W=1 high");
      run_pattern(5, 7, "R6 W>P low");
      run_pattern(4, 5, "R6 W=P+1 low");
   endtask

   task automatic test_hold;
      int bad = 0;
      run_pattern(4, 4, "R5 setup for hold");
      wr(8'h10, 32'h1);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (pwm_out !== 1'b0) bad++;
      end
      chk(bad == 0, "R7 output low while held", bad, 0);
      rd_expect(8'h10, 32'h1, "R7 hold bit reads back");
      wr(8'h10, 32'h0);
   endtask

   task automatic test_staged_load;
      int run = 0, n_runs = 0, first = 0, second = 0;
      bit prev = 0;
      wr(8'h10, 32'h1);
      wr(8'h14, 10);
      wr(8'h18, 3);
      wr(8'h10, 32'h3);
      wr(8'h10, 32'h0);      // running, counter at 9 in this cycle
      wr(8'h18, 6);          // staged only
      wr(8'h10, 32'h2);      // load mid-period
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (pwm_out) run++;
         else if (prev) begin
            n_runs++;
            if (n_runs == 1) first = run;
            if (n_runs == 2) second = run;
            run = 0;
         end
         prev = pwm_out;
      end
      chk(first == 3, "R8 staged width without load keeps old pulse", first, 3);
      chk(second == 6, "R9 load applied at next period boundary", second, 6);
      rd_expect(8'h10, 32'h0, "R8 load bit reads back zero");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      test_reset_state();
      test_regs();
      test_patterns();
      test_hold();
      test_staged_load();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule